// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

This block watches over system software from a byte-wide register port. Software arms it with one write of a control byte to a fixed register offset. The byte's top bit enables counting and its low three bits pick one of eight timeout lengths. While the timer is armed it counts half-second ticks from a clock prescaler and blinks a status LED. Software must write the register again before the chosen length runs out. If no write arrives in time, the block drives an active-low reset pulse of fixed width and then returns to the disarmed state.

The timeout is measured in half-second ticks. One coarse unit is `BASE_TICKS` ticks, which is 12 ticks or about six seconds. Code 0 gives half a unit. Code n (1 to 7) gives n units. The prescaler ratio is a parameter, so a test build can shrink a tick to a few clock cycles. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `wdt_top`

## Requirements
- R1: After reset the timer is disarmed. `wd_rst_n` is high, `led` is low, and no timeout ever occurs until an arming write arrives.
- R2: A write takes effect only when `wr_en` is high and `wr_addr` equals `REG_OFS` (default 3). A write to any other offset has no effect.
- R3: In the control byte, bit 7 = 1 arms the timer and bits 2:0 select the period code. Bits 6:3 are ignored, so 0xF8 behaves like 0x80.
- R4: The timeout length L in ticks is `BASE_TICKS/2` for code 0 and `BASE_TICKS*n` for code n. A tick is `TICK_DIV` clock cycles. `wd_rst_n` falls exactly `L*TICK_DIV` clock cycles after the edge that accepts the arming write.
- R5: The reset pulse holds `wd_rst_n` low for exactly `PULSE_W` clock cycles, after which it returns high.
- R6: After a reset pulse the timer is disarmed. No further pulse occurs and `led` goes low.
- R7: Any accepted write with bit 7 set while the timer is armed is a retrigger. The elapsed count restarts from the edge of that write.
- R8: The period code written by a retrigger applies from that write onward.
- R9: An accepted write with bit 7 clear disarms the timer. No timeout follows and `led` goes low.
- R10: While armed, `led` starts low and toggles on every tick, so it first rises `TICK_DIV` cycles after the arming edge. Whenever the timer is disarmed, `led` is low.
- R11: A write accepted on the same edge as the final tick counts as a retrigger. No pulse is produced, and a full new period starts from that edge.
- R12: Writes are ignored while `wd_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Register offset of the write |
| wr_data | input | 8 | Control byte: bit 7 arm, bits 2:0 period code |
| wd_rst_n | output | 1 | Active-low watchdog reset pulse |
| led | output | 1 | Status LED, blinks while armed |

## Verification
Two events can land on the same clock edge: the tick that ends the period, and a software write that retriggers the timer. The bench arms the shortest period, counts cycles from the arming edge, and places a second write so that it is accepted on exactly the edge where the pulse would otherwise start. The result is judged at the ports in two ways. First, `wd_rst_n` must stay high through that edge. Second, the next fall must come exactly one full period after the colliding write, which shows the write restarted the count rather than being lost.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned ARM_BIT = 7;
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1;

  // timeout in ticks: half a unit for code 0, n units otherwise
  function automatic int unsigned period_ticks(input logic [CODE_W-1:0] code,
                                               input int unsigned base);
    if (code == '0) return base / 2;
    return base * int'(code);
  endfunction
endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned REG_OFS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                busy,
  input  logic                fire,
  output logic                armed,
  output logic [CODE_W-1:0]   code,
  output logic                kick
);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  logic              hit;
  logic              armed_d;
  logic [CODE_W-1:0] code_d;
  logic              unused_mid_bits;

  assign unused_mid_bits = &{1'b0, wr_data[ARM_BIT-1:CODE_W]};
  assign hit  = wr_en && (wr_addr == OFS) && !busy;
  assign kick = hit;

  always_comb begin
    armed_d = armed;
    code_d  = code;
    if (fire) begin
      armed_d = 1'b0;
    end else if (hit) begin
      armed_d = wr_data[ARM_BIT];
      code_d  = wr_data[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      code  <= '0;
    end else begin
      armed <= armed_d;
      code  <= code_d;
    end
  end

  // R6: a timeout leaves the timer disarmed
  p_fire_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed) else $error("fire did not disarm");

  // R12: nothing is accepted while the pulse is out
  p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(armed) && $stable(code))) else $error("write taken during pulse");
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = run && !clr;
  assign tick   = cnt_en && (cnt == LAST);

  always_comb begin
    cnt_d = cnt;
    if (!cnt_en || cnt == LAST) cnt_d = '0;
    else                        cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R4: ticks are spaced, never back to back
      p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick) else $error("ticks adjacent");
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic [CODE_W-1:0] code,
  input  logic              kick,
  input  logic              tick,
  output logic              fire,
  output logic              led
);
  localparam int unsigned EW = $clog2(BASE_TICKS * MAX_CODE + 1);

  logic [EW-1:0] elapsed;
  logic [EW-1:0] elapsed_d;
  logic [EW-1:0] limit;
  logic          led_d;

  assign limit = EW'(period_ticks(code, BASE_TICKS));
  assign fire  = armed && tick && !kick && (elapsed == limit - 1'b1);

  always_comb begin
    elapsed_d = elapsed;
    if (!armed || kick) elapsed_d = '0;
    else if (tick)      elapsed_d = elapsed + 1'b1;
  end

  always_comb begin
    led_d = led;
    if (!armed)    led_d = 1'b0;
    else if (tick) led_d = !led;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      led     <= 1'b0;
    end else begin
      elapsed <= elapsed_d;
      led     <= led_d;
    end
  end

  // R7: a retrigger restarts the count
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (elapsed == '0)) else $error("count not cleared");
  // R11: a write on the final tick wins over the timeout
  p_kick_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> !fire) else $error("fire with write");
  // R10: LED dark when disarmed
  p_led_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !led) else $error("led lit while disarmed");
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic wd_rst_n,
  output logic busy
);
  localparam int unsigned PW = $clog2(PULSE_W + 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] cnt_d;
  logic          out_q;
  logic          out_d;

  always_comb begin
    cnt_d = cnt;
    out_d = out_q;
    if (fire) begin
      cnt_d = PW'(PULSE_W - 1);
      out_d = 1'b0;
    end else if (cnt != '0) begin
      cnt_d = cnt - 1'b1;
    end else begin
      out_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      out_q <= 1'b1;
    end else begin
      cnt   <= cnt_d;
      out_q <= out_d;
    end
  end

  assign wd_rst_n = out_q;
  assign busy     = !out_q;

  // R5: the pulse starts on the edge after fire
  p_pulse_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !wd_rst_n) else $error("pulse missing");
  // R12: no retimeout while the pulse is out
  p_no_refire_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire) else $error("fire during pulse");
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFS    = 3,
  parameter int unsigned TICK_DIV   = 25_000_000,
  parameter int unsigned BASE_TICKS = 12,
  parameter int unsigned PULSE_W    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              wd_rst_n,
  output logic              led
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              armed;
  logic [CODE_W-1:0] code;
  logic              kick;
  logic              tick;
  logic              fire;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  wdt_regif #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_regif (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .fire(fire),
    .armed(armed), .code(code), .kick(kick)
  );

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_int_n), .run(armed), .clr(kick), .tick(tick)
  );

  wdt_core #(.BASE_TICKS(BASE_TICKS)) u_core (
    .clk(clk), .rst_n(rst_int_n), .armed(armed), .code(code),
    .kick(kick), .tick(tick), .fire(fire), .led(led)
  );

  wdt_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk(clk), .rst_n(rst_int_n), .fire(fire), .wd_rst_n(wd_rst_n), .busy(busy)
  );

  // R1: no timeout can start from a disarmed timer
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !armed |-> !fire) else $error("fire while disarmed");
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int unsigned D = 4;
  localparam int unsigned B = 12;
  localparam int unsigned W = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       wd_rst_n;
  logic       led;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = !clk;

  wdt_top #(.ADDR_W(4), .REG_OFS(3), .TICK_DIV(D), .BASE_TICKS(B), .PULSE_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wd_rst_n(wd_rst_n), .led(led)
  );

  function automatic int unsigned cyc(input int unsigned code);
    return (code == 0 ? B / 2 : B * code) * D;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitn(input int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called right after the write task; l = cycles to the fall
  task automatic expect_timeout(input string req, input int unsigned l);
    waitn(l - 1); chk(req, wd_rst_n, 1'b1);
    waitn(1);     chk(req, wd_rst_n, 1'b0);
    waitn(W - 1); chk({req, " R5"}, wd_rst_n, 1'b0);
    waitn(1);     chk({req, " R5"}, wd_rst_n, 1'b1);
  endtask

  task automatic quiet_for(input string req, input int unsigned n);
    bit low = 0;
    for (int i = 0; i < n; i++) begin
      waitn(1);
      if (wd_rst_n !== 1'b1) low = 1;
    end
    chk(req, low, 1'b0);
    chk(req, led, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reset rst_out", wd_rst_n, 1'b1);
    chk("R1 reset led", led, 1'b0);
    quiet_for("R1 idle", 400);
  endtask

  task automatic t_bad_addr();
    bus_wr(4'd2, 8'h80);
    quiet_for("R2 other offset", 400);
  endtask

  task automatic t_code0_mid_bits();
    bus_wr(4'd3, 8'hF8);
    expect_timeout("R3 R4 code0", cyc(0));
    quiet_for("R6 after pulse", 400);
  endtask

  task automatic t_codes();
    bus_wr(4'd3, 8'h81);
    expect_timeout("R4 code1", cyc(1));
    bus_wr(4'd3, 8'h87);
    expect_timeout("R4 code7", cyc(7));
  endtask

  task automatic t_retrigger();
    bus_wr(4'd3, 8'h81);
    waitn(40);
    bus_wr(4'd3, 8'h81);
    expect_timeout("R7 retrigger", cyc(1));
  endtask

  task automatic t_new_period();
    bus_wr(4'd3, 8'h83);
    waitn(10);
    bus_wr(4'd3, 8'h80);
    expect_timeout("R8 new period", cyc(0));
  endtask

  task automatic t_disarm();
    bus_wr(4'd3, 8'h81);
    waitn(20);
    bus_wr(4'd3, 8'h01);
    waitn(2);
    quiet_for("R9 disarm", 400);
  endtask

  task automatic t_led();
    bus_wr(4'd3, 8'h82);
    waitn(D - 1); chk("R10 led before tick", led, 1'b0);
    waitn(1);     chk("R10 led first tick", led, 1'b1);
    waitn(D);     chk("R10 led second tick", led, 1'b0);
    waitn(D);     chk("R10 led third tick", led, 1'b1);
    bus_wr(4'd3, 8'h00);
    waitn(1);
    chk("R10 led off disarmed", led, 1'b0);
  endtask

  task automatic t_collision();
    bus_wr(4'd3, 8'h80);
    waitn(cyc(0) - 1);
    bus_wr(4'd3, 8'h80);   // accepted on the edge of the final tick
    chk("R11 no pulse at collision", wd_rst_n, 1'b1);
    expect_timeout("R11 full period after collision", cyc(0));
  endtask

  task automatic t_write_in_pulse();
    bus_wr(4'd3, 8'h80);
    waitn(cyc(0) + 1);
    chk("R12 in pulse", wd_rst_n, 1'b0);
    bus_wr(4'd3, 8'h80);
    waitn(W);
    quiet_for("R12 write ignored", 400);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);
    t_reset();
    t_bad_addr();
    t_code0_mid_bits();
    t_codes();
    t_retrigger();
    t_new_period();
    t_disarm();
    t_led();
    t_collision();
    t_write_in_pulse();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule